// File: doc/BRIEF.md
# Fuse Macro Byte-Read Sequencer

This block turns a single read request into the slow pin sequence that a one-time-programmable fuse array macro needs. A request names a starting byte address and a number of bytes. The sequencer selects the macro and puts it into read (load) mode. For each byte it presents the address and pulses the strobe, holding each step for a programmable settle interval. It captures the macro's 8-bit output and hands the byte on as a one-cycle pulse on the read stream. After the last byte it writes the standby pin pattern and drops busy.

All macro pins are carried in one 16-bit control word. The word's bit layout is fixed, because the macro side decodes it. The settle interval is given in clock cycles through a parameter, so it can be set to the minimum settle time of 1 µs at the chosen clock frequency. Programming fuses is not part of this block.

Top module: `fuse_rd_seq`

## Requirements
- R1: During and after reset, `busy` and `rd_valid` are low and `fuse_ctl` holds the standby pattern 16'h0009.
- R2: A request with `req_valid` high while `busy` is low is accepted at that clock edge. In the next cycle `busy` is high. If the count is nonzero, `fuse_ctl` is 16'h000C in that cycle: load and program-enable-bar set, chip-select-bar low, address field zero.
- R3: Control word layout: bit 0 is chip-select-bar, bit 1 is strobe, bit 2 is load, bit 3 is program-enable-bar, bits 5:4 are zero, and bits 15:6 carry the 10-bit byte address.
- R4: The address field is cleared for exactly one cycle and then set to the current address. After SETTLE_CYC cycles the strobe rises and stays high for SETTLE_CYC cycles, then stays low for SETTLE_CYC cycles. Inside a transfer, every strobe-low stretch before a rise (entry included) lasts 2*SETTLE_CYC+1 cycles.
- R5: `rd_valid` pulses for one cycle, in the first cycle the strobe is low again. `rd_data` then equals the value `fuse_dout` had in the last strobe-high cycle, and the address field still shows that byte's address.
- R6: The address increases by one per byte and wraps from 1023 to 0.
- R7: After the last byte's final settle interval, `fuse_ctl` returns to 16'h0009 (program-enable-bar and chip-select-bar high) in the same cycle that `busy` falls. While `busy` is low, `fuse_ctl` is always 16'h0009.
- R8: Requests arriving while `busy` is high are ignored: they add no bytes, do not alter addresses, and do not start a further transfer.
- R9: A count of zero holds `busy` high for exactly one cycle with `fuse_ctl` at 16'h0009, no strobe and no `rd_valid`.
- R10: A transfer produces exactly as many strobe pulses and `rd_valid` pulses as the requested count.
- R11: The strobe is only ever high while chip-select-bar is low, load is high and program-enable-bar is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 10 | Starting byte address |
| req_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | High from accept until standby is written |
| fuse_ctl | output | 16 | Control word to the fuse macro pins |
| fuse_dout | input | 8 | Data byte from the fuse macro |
| rd_valid | output | 1 | One-cycle pulse per byte read |
| rd_data | output | 8 | Byte captured from the macro |

## Verification
The checker watches the pin invariants on every cycle. The strobe is gated by chip-select, load and program-enable, and the address stays still while the strobe is high. Each read pulse coincides with a strobe fall and falls inside busy. Idle always means the standby pattern, and busy rises only onto the entry or standby pattern. The bench scenarios cover the timing and content side. They measure each settle stretch in cycles, compare every byte and address against a model of the fuse array, and count strobes per transfer. They also exercise address wrap at 1023, a zero-length request, and a request issued mid-transfer.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    localparam int FUSE_ADDR_W = 10;
    localparam int FUSE_DATA_W = 8;
    localparam int FUSE_CTL_W  = 16;

    // Pin word as decoded by the macro: addr[15:6], spare[5:4], pgen_n[3], load[2], strobe[1], cs_n[0]
    typedef struct packed {
        logic [FUSE_ADDR_W-1:0] addr;
        logic [1:0]             spare;
        logic                   pgen_n;
        logic                   load;
        logic                   strobe;
        logic                   cs_n;
    } fuse_ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_CLR,
        ST_ADDR,
        ST_STRB,
        ST_DROP,
        ST_STBY
    } seq_st_e;

    function automatic fuse_ctl_t ctl_standby();
        fuse_ctl_t c;
        c        = '0;
        c.pgen_n = 1'b1;
        c.cs_n   = 1'b1;
        return c;
    endfunction

    function automatic fuse_ctl_t ctl_entry();
        fuse_ctl_t c;
        c        = '0;
        c.pgen_n = 1'b1;
        c.load   = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/fuse_settle_timer.sv
module fuse_settle_timer #(
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int TW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= TW'(SETTLE_CYC - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fuse_xfer_cnt.sv
module fuse_xfer_cnt
    import fuse_rd_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [FUSE_ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]       len,
    input  logic                   step,
    output logic [FUSE_ADDR_W-1:0] cur_addr,
    output logic                   done
);
    logic [LEN_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            remaining <= '0;
        end else if (load) begin
            cur_addr  <= start_addr;
            remaining <= len;
        end else if (step) begin
            cur_addr  <= cur_addr + 1'b1;   // wraps inside the 10-bit field
            remaining <= remaining - 1'b1;
        end
    end

    assign done = (remaining == '0);
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_zero,
    input  logic                   tmr_expired,
    input  logic                   xfer_done,
    input  logic [FUSE_ADDR_W-1:0] cur_addr,
    input  logic [FUSE_DATA_W-1:0] macro_dout,
    output logic                   tmr_load,
    output logic                   cnt_load,
    output logic                   cnt_step,
    output logic                   busy,
    output fuse_ctl_t              ctl,
    output logic                   rd_valid,
    output logic [FUSE_DATA_W-1:0] rd_data
);
    seq_st_e st;

    logic accept;
    assign accept = (st == ST_IDLE) && req_valid;

    always_comb begin
        tmr_load = 1'b0;
        case (st)
            ST_IDLE: tmr_load = req_valid && !req_zero;
            ST_CLR:  tmr_load = 1'b1;
            ST_ADDR: tmr_load = tmr_expired;
            ST_STRB: tmr_load = tmr_expired;
            default: tmr_load = 1'b0;
        endcase
    end

    assign cnt_load = accept;
    assign cnt_step = (st == ST_STRB) && tmr_expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ctl      <= ctl_standby();
            busy     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        busy <= 1'b1;
                        if (req_zero) begin
                            st <= ST_STBY;
                        end else begin
                            ctl <= ctl_entry();
                            st  <= ST_ENTRY;
                        end
                    end
                end
                ST_ENTRY: begin
                    if (tmr_expired) begin
                        ctl.addr <= '0;
                        st       <= ST_CLR;
                    end
                end
                ST_CLR: begin
                    ctl.addr <= cur_addr;
                    st       <= ST_ADDR;
                end
                ST_ADDR: begin
                    if (tmr_expired) begin
                        ctl.strobe <= 1'b1;
                        st         <= ST_STRB;
                    end
                end
                ST_STRB: begin
                    if (tmr_expired) begin
                        ctl.strobe <= 1'b0;
                        rd_valid   <= 1'b1;
                        rd_data    <= macro_dout;
                        st         <= ST_DROP;
                    end
                end
                ST_DROP: begin
                    if (tmr_expired) begin
                        if (xfer_done) begin
                            ctl  <= ctl_standby();
                            busy <= 1'b0;
                            st   <= ST_IDLE;
                        end else begin
                            ctl.addr <= '0;
                            st       <= ST_CLR;
                        end
                    end
                end
                ST_STBY: begin
                    ctl  <= ctl_standby();
                    busy <= 1'b0;
                    st   <= ST_IDLE;
                end
                default: begin
                    ctl  <= ctl_standby();
                    busy <= 1'b0;
                    st   <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int SETTLE_CYC = 100,
    parameter int LEN_W      = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [FUSE_ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]       req_len,
    output logic                   busy,
    output logic [FUSE_CTL_W-1:0]  fuse_ctl,
    input  logic [FUSE_DATA_W-1:0] fuse_dout,
    output logic                   rd_valid,
    output logic [FUSE_DATA_W-1:0] rd_data
);
    logic                   tmr_load;
    logic                   tmr_expired;
    logic                   cnt_load;
    logic                   cnt_step;
    logic                   xfer_done;
    logic [FUSE_ADDR_W-1:0] cur_addr;
    fuse_ctl_t              ctl;

    fuse_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    fuse_xfer_cnt #(.LEN_W(LEN_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .load       (cnt_load),
        .start_addr (req_addr),
        .len        (req_len),
        .step       (cnt_step),
        .cur_addr   (cur_addr),
        .done       (xfer_done)
    );

    fuse_rd_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_zero    (req_len == '0),
        .tmr_expired (tmr_expired),
        .xfer_done   (xfer_done),
        .cur_addr    (cur_addr),
        .macro_dout  (fuse_dout),
        .tmr_load    (tmr_load),
        .cnt_load    (cnt_load),
        .cnt_step    (cnt_step),
        .busy        (busy),
        .ctl         (ctl),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    assign fuse_ctl = ctl;
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic [15:0] fuse_ctl,
    input logic        rd_valid
);
    // R11
    strobe_gated_chk: assert property (@(posedge clk) disable iff (rst)
        fuse_ctl[1] |-> (!fuse_ctl[0] && fuse_ctl[2] && fuse_ctl[3]));

    // R4
    strobe_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (fuse_ctl[1] && $past(fuse_ctl[1])) |-> $stable(fuse_ctl[15:6]));

    // R5
    rd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $fell(fuse_ctl[1]));

    // R7
    idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fuse_ctl == 16'h0009));

    // R9
    rd_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    // R2
    busy_rise_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (fuse_ctl == 16'h000C || fuse_ctl == 16'h0009));
endmodule

bind fuse_rd_seq fuse_rd_seq_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .fuse_ctl (fuse_ctl),
    .rd_valid (rd_valid)
);

// File: tb/fuse_rd_seq_tb_top.sv
module fuse_rd_seq_tb_top;
    localparam int S  = 4;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [9:0]    req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          busy;
    logic [15:0]   fuse_ctl;
    logic [7:0]    fuse_dout;
    logic          rd_valid;
    logic [7:0]    rd_data;

    always #10 clk = ~clk;

    fuse_rd_seq #(.SETTLE_CYC(S), .LEN_W(LW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .busy      (busy),
        .fuse_ctl  (fuse_ctl),
        .fuse_dout (fuse_dout),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    function automatic logic [7:0] fuse_val(logic [9:0] a);
        return a[7:0] ^ {4{a[9:8]}} ^ 8'h5A;
    endfunction

    // behavioural fuse array: answers only while selected, loading and strobed
    always_comb begin
        if (fuse_ctl[1] && !fuse_ctl[0] && fuse_ctl[2])
            fuse_dout = fuse_val(fuse_ctl[15:6]);
        else
            fuse_dout = 8'hEE;
    end

    int n_chk  = 0;
    int n_fail = 0;
    int n_strobe = 0;
    logic [17:0] exp_q[$];

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // monitor: timing of strobe stretches and scoreboard of bytes
    int lo_cnt = 0;
    int hi_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!busy) begin
                lo_cnt = 0;
                hi_cnt = 0;
            end else if (fuse_ctl[1]) begin
                if (hi_cnt == 0) begin
                    n_strobe++;
                    // R4 low stretch before each rise
                    check(lo_cnt == 2*S+1, "R4", "strobe low stretch", lo_cnt, 2*S+1);
                end
                hi_cnt++;
                lo_cnt = 0;
            end else begin
                if (hi_cnt != 0)
                    check(hi_cnt == S, "R4", "strobe high stretch", hi_cnt, S);
                hi_cnt = 0;
                lo_cnt++;
            end
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected byte", int'(rd_data), 0);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    // R6 address sequence and wrap
                    check(fuse_ctl[15:6] == e[17:8], "R6", "byte address", int'(fuse_ctl[15:6]), int'(e[17:8]));
                    // R5 captured data
                    check(rd_data == e[7:0], "R5", "byte data", int'(rd_data), int'(e[7:0]));
                end
            end
        end
    end

    task automatic xfer(int a, int n, bit poke);
        int strb0;
        while (busy) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            logic [9:0] ad;
            ad = 10'(a + i);
            exp_q.push_back({ad, fuse_val(ad)});
        end
        strb0 = n_strobe;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 10'(a);
        req_len   = LW'(n);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
        if (n != 0) begin
            // R3 entry pattern: load bit2, pgen_n bit3, cs_n bit0 low
            check(fuse_ctl == 16'h000C, "R2", "entry control word", int'(fuse_ctl), 16'h000C);
        end else begin
            check(fuse_ctl == 16'h0009, "R9", "zero count word", int'(fuse_ctl), 16'h0009);
            @(negedge clk);
            check(busy == 1'b0, "R9", "zero count busy one cycle", int'(busy), 0);
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1;
            req_addr  = 10'(a + 300);
            req_len   = LW'(5);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        // R7 standby written as busy falls
        check(fuse_ctl == 16'h0009, "R7", "standby word", int'(fuse_ctl), 16'h0009);
        check(exp_q.size() == 0, "R10", "bytes outstanding", exp_q.size(), 0);
        check(n_strobe - strb0 == n, "R10", "strobe count", n_strobe - strb0, n);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8", "no extra transfer", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(rd_valid == 1'b0, "R1", "rd_valid in reset", int'(rd_valid), 0);
        check(fuse_ctl == 16'h0009, "R1", "ctl in reset", int'(fuse_ctl), 16'h0009);
        rst = 1'b0;
        @(negedge clk);
        check(fuse_ctl == 16'h0009, "R1", "ctl after reset", int'(fuse_ctl), 16'h0009);
        xfer(5, 3, 1'b0);
        xfer(1022, 4, 1'b0);   // R6 wrap
        xfer(0, 0, 1'b0);      // R9
        xfer(100, 2, 1'b1);    // R8 request during busy
        xfer(1023, 1, 1'b0);
        xfer(37, 6, 1'b0);
        xfer(512, 0, 1'b0);
        summary();
    end

    initial begin
        #(20 * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule